// File: doc/BRIEF.md
# Host Frame Interval Timer

This block paces the frames of a USB-style host port. It counts PHY clock cycles and raises a one-cycle start-of-frame strobe at the end of each interval. In full or low speed the strobe marks an SOF. In high speed it marks a micro-SOF or a keep-alive. The interval is a 16-bit cycle count held in a 32-bit register. Software can write that count. If software never writes it, the block derives the count from the PHY clock select code and the speed-mode flag.

Bit 16 of the register is a reload-control bit, and it picks when a new count reaches the running timer. With reload enabled, a new count takes effect at the next frame boundary. With reload disabled, a new count waits until the port is disabled and enabled again. While the port is disabled, the timer is parked and the strobe stays low. Port enable is expected to be low when reset is released, so that the first parked cycle loads the timer.

Top module: `frame_timer`

## Requirements
- R1: During and right after reset, `reg_rdata` reads 0x0000EA60 when `clk_sel`=0 and `hs_mode`=0, and `sof_pulse` is low. The reload bit and the programmed flag are clear after reset.
- R2: Until an interval write is accepted, `reg_rdata[15:0]` and the timer use a default count, which is `clk_sel` MHz × 1000 in full speed or `clk_sel` MHz × 125 when `hs_mode`=1. The `clk_sel` codes are 0 for 60 MHz, 1 for 48 MHz, 2 for 6 MHz and 3 for 60 MHz. This gives 60000/7500, 48000/6000, 6000/750 and 60000/7500 cycles.
- R3: A write to `reg_wdata[15:0]` is accepted only when `port_en` is high at that clock edge. A write made while `port_en` is low leaves the interval readback unchanged.
- R4: Bit 16 of every write is stored as the reload-control bit, whatever the state of `port_en`, and reads back at `reg_rdata[16]` from the next cycle.
- R5: `reg_rdata[31:17]` always reads zero, and the write data on those bits has no effect.
- R6: Whenever `port_en` was low at the last edge, `sof_pulse` is low and `frame_count` equals the current interval minus 1. That interval is the written value or the default.
- R7: Counting enabled edges from the rise of `port_en`, `sof_pulse` is high for exactly one cycle after edges X, 2X, 3X and so on, where X is the active interval.
- R8: After enabled edge k, `frame_count` reads X-1-(k mod X), so it counts down by one per cycle and reloads to X-1 as the strobe rises.
- R9: With the reload bit at 1, an interval written mid-frame does not shorten or lengthen that frame. It becomes the period from the next frame boundary.
- R10: With the reload bit at 0, a newly written interval is not used while the port stays enabled. It becomes the period only after `port_en` goes low and high again.
- R11: Once an interval write is accepted, the written value replaces the default, and later changes of `clk_sel` or `hs_mode` change neither the readback nor the timer.
- R12: An interval of 0 behaves as an interval of 1: the strobe is high on every enabled cycle and `frame_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per high cycle |
| reg_wdata | input | 32 | Register write data: bit 16 is reload control, bits 15:0 are the interval |
| reg_rdata | output | 32 | Register readback: reserved zeros, reload bit, effective interval |
| port_en | input | 1 | Port enable: gates interval writes and runs the timer |
| hs_mode | input | 1 | 1 selects the high-speed (125 µs) default interval |
| clk_sel | input | 2 | PHY clock select code used for the default interval |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| frame_count | output | 16 | Current down-count of the frame timer |

## Verification
`reg_rdata` is combinational on the stored fields and the select inputs, so a write shows in the readback in the cycle after its edge. `sof_pulse` and `frame_count` come from registers and so are due one edge after the enabled edge that produces them. The bench drives all inputs and samples all outputs on the falling edge. Each check therefore sees exactly the state left by the last rising edge. Expected strobe and count values come from the count of enabled edges since `port_en` rose, and a mid-frame write is placed at a known edge so that the old and new periods can be told apart.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    PHY_60M  = 2'd0,
    PHY_48M  = 2'd1,
    PHY_6M   = 2'd2,
    PHY_ALT  = 2'd3
  } phy_sel_e;

  localparam int unsigned FS_FRAME_US  = 1000;
  localparam int unsigned HS_FRAME_DIV = 8;

  function automatic int unsigned phy_mhz(phy_sel_e sel);
    case (sel)
      PHY_48M: return 48;
      PHY_6M:  return 6;
      default: return 60;
    endcase
  endfunction
endpackage

// File: rtl/ft_default.sv
module ft_default
  import frame_timer_pkg::*;
#(
  parameter int unsigned IVAL_W = 16
) (
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              hs_mode,
  output logic [IVAL_W-1:0] dflt_ival
);
  localparam int unsigned HS_FRAME_US = FS_FRAME_US / HS_FRAME_DIV;

  int unsigned mhz;

  always_comb begin
    mhz = phy_mhz(phy_sel_e'(clk_sel));
    if (hs_mode) dflt_ival = IVAL_W'(mhz * HS_FRAME_US);
    else         dflt_ival = IVAL_W'(mhz * FS_FRAME_US);
  end
endmodule

// File: rtl/ft_regs.sv
module ft_regs #(
  parameter int unsigned IVAL_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RST_IVAL = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              port_en,
  input  logic [IVAL_W-1:0] dflt_ival,
  output logic [DATA_W-1:0] rdata,
  output logic              reload_en,
  output logic [IVAL_W-1:0] eff_ival
);
  localparam int unsigned RLD_BIT = IVAL_W;
  localparam int unsigned RSV_W   = DATA_W - IVAL_W - 1;
  localparam logic [IVAL_W-1:0] RST_V = IVAL_W'(RST_IVAL);

  logic [IVAL_W-1:0] ival_q;
  logic              prog_q;
  logic              rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_q <= RST_V;
      prog_q <= 1'b0;
      rld_q  <= 1'b0;
    end else if (wr_en) begin
      rld_q <= wdata[RLD_BIT];
      if (port_en) begin
        ival_q <= wdata[IVAL_W-1:0];
        prog_q <= 1'b1;
      end
    end
  end

  always_comb begin
    eff_ival  = prog_q ? ival_q : dflt_ival;
    reload_en = rld_q;
    rdata     = {{RSV_W{1'b0}}, rld_q, eff_ival};
  end
endmodule

// File: rtl/ft_counter.sv
module ft_counter #(
  parameter int unsigned IVAL_W   = 16,
  parameter int unsigned RST_IVAL = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              reload_en,
  input  logic [IVAL_W-1:0] eff_ival,
  output logic [IVAL_W-1:0] count,
  output logic              sof
);
  localparam logic [IVAL_W-1:0] ONE    = IVAL_W'(1);
  localparam logic [IVAL_W-1:0] RST_M1 = IVAL_W'(RST_IVAL - 1);

  logic [IVAL_W-1:0] act_m1_q;
  logic [IVAL_W-1:0] cnt_q;
  logic              sof_q;
  logic [IVAL_W-1:0] load_v;

  // A zero interval is clamped to one cycle.
  always_comb begin
    load_v = (eff_ival == '0) ? '0 : eff_ival - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_m1_q <= RST_M1;
      cnt_q    <= RST_M1;
      sof_q    <= 1'b0;
    end else if (!port_en) begin
      act_m1_q <= load_v;
      cnt_q    <= load_v;
      sof_q    <= 1'b0;
    end else if (cnt_q == '0) begin
      sof_q <= 1'b1;
      if (reload_en) begin
        act_m1_q <= load_v;
        cnt_q    <= load_v;
      end else begin
        cnt_q <= act_m1_q;
      end
    end else begin
      cnt_q <= cnt_q - ONE;
      sof_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign sof   = sof_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import frame_timer_pkg::*;
#(
  parameter int unsigned IVAL_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RST_IVAL = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              port_en,
  input  logic              hs_mode,
  input  logic [SEL_W-1:0]  clk_sel,
  output logic              sof_pulse,
  output logic [IVAL_W-1:0] frame_count
);
  logic [IVAL_W-1:0] dflt_ival;
  logic [IVAL_W-1:0] eff_ival;
  logic              reload_en;

  ft_default #(.IVAL_W(IVAL_W)) u_dflt (
    .clk_sel   (clk_sel),
    .hs_mode   (hs_mode),
    .dflt_ival (dflt_ival)
  );

  ft_regs #(.IVAL_W(IVAL_W), .DATA_W(DATA_W), .RST_IVAL(RST_IVAL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wdata     (reg_wdata),
    .port_en   (port_en),
    .dflt_ival (dflt_ival),
    .rdata     (reg_rdata),
    .reload_en (reload_en),
    .eff_ival  (eff_ival)
  );

  ft_counter #(.IVAL_W(IVAL_W), .RST_IVAL(RST_IVAL)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .reload_en (reload_en),
    .eff_ival  (eff_ival),
    .count     (frame_count),
    .sof       (sof_pulse)
  );
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int unsigned IVAL_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              port_en,
  input logic              sof_pulse,
  input logic [IVAL_W-1:0] frame_count
);
  localparam int unsigned RLD_BIT = IVAL_W;

  // R3: an accepted write shows in the readback on the next cycle
  p_wr_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && port_en) |=> (reg_rdata[IVAL_W-1:0] == $past(reg_wdata[IVAL_W-1:0])));

  // R4: the reload bit follows every write
  p_reload_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[RLD_BIT] == $past(reg_wdata[RLD_BIT])));

  // R5: reserved bits read zero
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:RLD_BIT+1] == '0);

  // R6: no strobe after a disabled edge
  p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sof_pulse);

  // R7: the strobe lasts one cycle when the interval exceeds one
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && port_en && frame_count != '0) |=> !sof_pulse);

  // R8: the count steps down by one on each enabled edge
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && frame_count != '0) |=> (frame_count == $past(frame_count) - IVAL_W'(1)));
endmodule

bind frame_timer ft_checker #(.IVAL_W(IVAL_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .port_en     (port_en),
  .sof_pulse   (sof_pulse),
  .frame_count (frame_count)
);

// File: tb/tb_frame_timer.sv
module tb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        port_en = 1'b0;
  logic        hs_mode = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic        sof_pulse;
  logic [15:0] frame_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_en(port_en), .hs_mode(hs_mode),
    .clk_sel(clk_sel), .sof_pulse(sof_pulse), .frame_count(frame_count)
  );

  function automatic int unsigned exp_default(logic [1:0] sel, logic hs);
    int unsigned mhz;
    case (sel)
      2'd1: mhz = 48;
      2'd2: mhz = 6;
      default: mhz = 60;
    endcase
    return hs ? mhz * 125 : mhz * 1000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tick(input logic rld, input logic [15:0] ival);
    reg_wr    = 1'b1;
    reg_wdata = {15'h5A5A, rld, ival};
    tick();
    reg_wr    = 1'b0;
  endtask

  // Enabled run from the rise of port_en; x is the clamped interval
  task automatic run_frames(input int x, input int n, input string tag);
    port_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      tick();
      chk(sof_pulse == ((k % x) == 0), {tag, " sof"}, sof_pulse, (k % x) == 0);
      chk(frame_count == 16'(x - 1 - (k % x)), {tag, " count"}, frame_count, x - 1 - (k % x));
    end
  endtask

  // Mid-frame write of 6 at edge 4 while running with 10
  task automatic midframe(input logic rld, input int n, input string tag);
    int ek;
    int ec;
    bit es;
    port_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      if (k == 4) begin reg_wr = 1'b1; reg_wdata = {15'h7FFF, rld, 16'd6}; end
      tick();
      reg_wr = 1'b0;
      if (!rld || k < 10) begin ec = 9 - (k % 10); es = (k % 10) == 0; end
      else begin ek = k - 10; ec = 5 - (ek % 6); es = (ek % 6) == 0; end
      chk(sof_pulse == es, {tag, " sof"}, sof_pulse, es);
      chk(frame_count == 16'(ec), {tag, " count"}, frame_count, ec);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int x;
    int e;
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);
    #1;
    chk(reg_rdata == 32'h0000EA60, "R1 rdata in reset", reg_rdata, 32'h0000EA60);
    chk(sof_pulse == 1'b0, "R1 sof in reset", sof_pulse, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk(reg_rdata == 32'h0000EA60, "R1 rdata after reset", reg_rdata, 32'h0000EA60);
    chk(frame_count == 16'd59999, "R6 parked count", frame_count, 59999);

    // R2: default table, parked count follows it (R6)
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        clk_sel = 2'(s);
        hs_mode = 1'(h);
        tick();
        e = exp_default(clk_sel, hs_mode);
        chk(reg_rdata[15:0] == 16'(e), "R2 default", reg_rdata[15:0], e);
        chk(frame_count == 16'(e - 1), "R6 parked default", frame_count, e - 1);
      end
    end

    // R3/R4/R5: write while disabled
    clk_sel = 2'd0; hs_mode = 1'b0;
    reg_wr = 1'b1; reg_wdata = 32'hFFFF_1234;
    tick();
    reg_wr = 1'b0;
    chk(reg_rdata[15:0] == 16'hEA60, "R3 dropped write", reg_rdata[15:0], 16'hEA60);
    chk(reg_rdata[16] == 1'b1, "R4 reload bit set", reg_rdata[16], 1);
    chk(reg_rdata[31:17] == '0, "R5 reserved zero", reg_rdata[31:17], 0);
    chk(sof_pulse == 1'b0, "R6 no strobe parked", sof_pulse, 0);
    wr_tick(1'b0, 16'd77);
    chk(reg_rdata == 32'h0000EA60, "R4 reload bit clear", reg_rdata, 32'h0000EA60);

    // R7/R8 on the default (6 MHz high speed = 750)
    clk_sel = 2'd2; hs_mode = 1'b1;
    tick();
    run_frames(750, 1600, "R7 default frame");
    port_en = 1'b0;
    tick();

    // R10: reload off, program 10
    port_en = 1'b1;
    wr_tick(1'b0, 16'd10);
    port_en = 1'b0;
    tick();
    chk(reg_rdata == 32'h0000000A, "R3 accepted write", reg_rdata, 10);
    chk(frame_count == 16'd9, "R6 parked programmed", frame_count, 9);
    clk_sel = 2'd1; hs_mode = 1'b0;
    tick();
    chk(reg_rdata[15:0] == 16'd10, "R11 readback keeps write", reg_rdata[15:0], 10);
    chk(frame_count == 16'd9, "R11 timer keeps write", frame_count, 9);
    midframe(1'b0, 35, "R10 held period");
    chk(reg_rdata[15:0] == 16'd6, "R10 readback new", reg_rdata[15:0], 6);
    port_en = 1'b0;
    tick();
    chk(frame_count == 16'd5, "R10 parked new", frame_count, 5);
    run_frames(6, 13, "R10 after re-enable");

    // R9: reload on
    port_en = 1'b1;
    wr_tick(1'b1, 16'd10);
    port_en = 1'b0;
    tick();
    midframe(1'b1, 30, "R9 next-boundary reload");
    port_en = 1'b0;
    tick();

    // R12: zero interval
    port_en = 1'b1;
    wr_tick(1'b1, 16'd0);
    port_en = 1'b0;
    tick();
    chk(frame_count == 16'd0, "R12 parked zero", frame_count, 0);
    run_frames(1, 6, "R12 zero interval");
    port_en = 1'b0;
    tick();

    // Random programmed intervals with dropped writes while parked
    for (int i = 0; i < 25; i++) begin
      x = 1 + int'($urandom % 40);
      port_en = 1'b1;
      wr_tick(1'($urandom % 2), 16'(x));
      port_en = 1'b0;
      clk_sel = 2'($urandom % 4);
      hs_mode = 1'($urandom % 2);
      wr_tick(1'($urandom % 2), 16'(100 + ($urandom % 50)));
      chk(reg_rdata[15:0] == 16'(x), "R3 random dropped", reg_rdata[15:0], x);
      chk(frame_count == 16'(x - 1), "R11 random parked", frame_count, x - 1);
      run_frames(x, 2 * x + int'($urandom % 5), "R8 random frames");
      port_en = 1'b0;
      tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule